// File: doc/BRIEF.md
# Zero-Overhead Loop Controller

This block lets a processor repeat a fixed stretch of code with no branch or compare instruction in the stream. A setup command hands it the address of the first body instruction, the address of the last one and a pass count. From then on it watches the program counter presented by the fetch stage. Each time that counter sits on the last body address and more passes remain, it overrides the next fetch address with the start address and lowers its own remaining-pass register. On the final pass it lets the sequential address through and flags completion.

The loop cannot be left early. A count of zero skips the body. Setting the start and end addresses equal repeats one instruction, so the fetch address is held for the given number of cycles. Only one loop level exists. A setup that arrives while the controller is busy is discarded and reported.

Top module: `zloop_ctrl`

## Requirements
- R1: After synchronous reset the controller is idle: `loop_active`, `redirect`, `loop_done` and `setup_err` are 0 and `next_pc` equals `pc`+1.
- R2: While idle, `next_pc` is `pc`+1 and `redirect` is 0 for every `pc` value.
- R3: A setup with count N>0 accepted while idle raises `loop_active` in the next cycle.
- R4: While active, when `pc` equals the end address and more than one pass remains, `redirect` is 1, `next_pc` is the start address, and one pass is taken off the remaining count.
- R5: While active and `pc` differs from the end address, `next_pc` is `pc`+1 and `redirect` is 0.
- R6: On the last pass, when `pc` equals the end address, `redirect` is 0, `next_pc` is end+1, `loop_done` is 1 for that cycle only, and `loop_active` is 0 in the next cycle.
- R7: A setup with count 0 never raises `loop_active`. In the cycle after setup, `redirect` is 1, `next_pc` is end+1 and `loop_done` is 1, and the controller is idle one cycle later.
- R8: With equal start and end addresses and count N, `next_pc` equals `pc` for N-1 cycles and then moves to end+1. The single instruction is therefore fetched N times.
- R9: A setup while a loop is running or a skip is pending is ignored: `setup_err` is 1 in that cycle, and the running loop keeps its addresses and pass count.
- R10: A loop with count N>0 reaches the end address exactly N times before `loop_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| setup_valid | input | 1 | Loop setup command strobe |
| setup_start | input | ADDR_W | First address of the loop body |
| setup_end | input | ADDR_W | Last address of the loop body |
| setup_count | input | CNT_W | Number of passes; 0 skips the body |
| pc | input | ADDR_W | Address currently being fetched |
| next_pc | output | ADDR_W | Address to fetch next |
| redirect | output | 1 | `next_pc` is not the sequential address |
| loop_active | output | 1 | A loop is running |
| loop_done | output | 1 | One-cycle pulse on loop completion or skip |
| setup_err | output | 1 | Setup rejected because the controller is busy |

## Verification
The bench models the fetch stage by feeding `next_pc` back into `pc`. It runs multi-instruction bodies with counts of 1, 3 and 5, which separate the final-pass release from the jump back and expose off-by-one errors in the pass counter. A start address equal to the end address checks that the fetch address is held rather than advanced. A zero count checks that the skip path releases to end+1 without entering the loop. A setup injected in the middle of a loop shows whether the running addresses or count were disturbed.

// File: rtl/zloop_pkg.sv
package zloop_pkg;

    typedef enum logic [1:0] {
        ZS_IDLE = 2'd0,
        ZS_RUN  = 2'd1,
        ZS_SKIP = 2'd2
    } zl_state_e;

    typedef enum logic [1:0] {
        ZA_SEQ  = 2'd0,
        ZA_BACK = 2'd1,
        ZA_EXIT = 2'd2,
        ZA_SKIP = 2'd3
    } zl_action_e;

    function automatic logic action_overrides(input zl_action_e a);
        return (a == ZA_BACK) || (a == ZA_SKIP);
    endfunction

    function automatic logic action_finishes(input zl_action_e a);
        return (a == ZA_EXIT) || (a == ZA_SKIP);
    endfunction

endpackage

// File: rtl/zloop_state.sv
module zloop_state
    import zloop_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              setup_valid,
    input  logic [ADDR_W-1:0] setup_start,
    input  logic [ADDR_W-1:0] setup_end,
    input  logic [CNT_W-1:0]  setup_count,
    input  zl_action_e        action,
    output zl_state_e         state_q,
    output logic [ADDR_W-1:0] start_q,
    output logic [ADDR_W-1:0] end_q,
    output logic [CNT_W-1:0]  rem_q,
    output logic              setup_err
);

    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_ZERO = '0;

    logic accept;

    assign accept    = setup_valid && (state_q == ZS_IDLE);
    assign setup_err = setup_valid && (state_q != ZS_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ZS_IDLE;
            start_q <= '0;
            end_q   <= '0;
            rem_q   <= '0;
        end else begin
            unique case (state_q)
                ZS_IDLE: begin
                    if (accept) begin
                        start_q <= setup_start;
                        end_q   <= setup_end;
                        rem_q   <= setup_count;
                        state_q <= (setup_count == CNT_ZERO) ? ZS_SKIP : ZS_RUN;
                    end
                end
                ZS_RUN: begin
                    if (action == ZA_BACK) begin
                        rem_q <= rem_q - CNT_ONE;
                    end else if (action == ZA_EXIT) begin
                        rem_q   <= CNT_ZERO;
                        state_q <= ZS_IDLE;
                    end
                end
                ZS_SKIP: state_q <= ZS_IDLE;
                default: state_q <= ZS_IDLE;
            endcase
        end
    end

    AST_ACCEPT_RUNS: assert property (@(posedge clk) disable iff (rst)
        (accept && setup_count != CNT_ZERO) |=> (state_q == ZS_RUN)); // R3

    AST_PASS_STEP: assert property (@(posedge clk) disable iff (rst)
        (state_q == ZS_RUN && action == ZA_BACK) |=> (rem_q == $past(rem_q) - CNT_ONE)); // R4

    AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (rst)
        (setup_err && state_q == ZS_RUN && action == ZA_SEQ)
            |=> ($stable(start_q) && $stable(end_q) && $stable(rem_q))); // R9

    AST_SKIP_ONCE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ZS_SKIP) |=> (state_q == ZS_IDLE)); // R7

endmodule

// File: rtl/zloop_match.sv
module zloop_match
    import zloop_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  zl_state_e         state_q,
    input  logic [ADDR_W-1:0] pc,
    input  logic [ADDR_W-1:0] end_q,
    input  logic [CNT_W-1:0]  rem_q,
    output zl_action_e        action
);

    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic at_end;
    assign at_end = (pc == end_q);

    always_comb begin
        action = ZA_SEQ;
        unique case (state_q)
            ZS_RUN: begin
                if (at_end) begin
                    action = (rem_q > CNT_ONE) ? ZA_BACK : ZA_EXIT;
                end
            end
            ZS_SKIP: action = ZA_SKIP;
            default: action = ZA_SEQ;
        endcase
    end

endmodule

// File: rtl/zloop_ctrl.sv
module zloop_ctrl
    import zloop_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              setup_valid,
    input  logic [ADDR_W-1:0] setup_start,
    input  logic [ADDR_W-1:0] setup_end,
    input  logic [CNT_W-1:0]  setup_count,
    input  logic [ADDR_W-1:0] pc,
    output logic [ADDR_W-1:0] next_pc,
    output logic              redirect,
    output logic              loop_active,
    output logic              loop_done,
    output logic              setup_err
);

    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    zl_state_e         state_q;
    zl_action_e        action;
    logic [ADDR_W-1:0] start_q;
    logic [ADDR_W-1:0] end_q;
    logic [CNT_W-1:0]  rem_q;

    zloop_state #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_state (
        .clk         (clk),
        .rst         (rst),
        .setup_valid (setup_valid),
        .setup_start (setup_start),
        .setup_end   (setup_end),
        .setup_count (setup_count),
        .action      (action),
        .state_q     (state_q),
        .start_q     (start_q),
        .end_q       (end_q),
        .rem_q       (rem_q),
        .setup_err   (setup_err)
    );

    zloop_match #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_match (
        .state_q (state_q),
        .pc      (pc),
        .end_q   (end_q),
        .rem_q   (rem_q),
        .action  (action)
    );

    always_comb begin
        unique case (action)
            ZA_BACK: next_pc = start_q;
            ZA_SKIP: next_pc = end_q + ADDR_ONE;
            default: next_pc = pc + ADDR_ONE;
        endcase
    end

    assign redirect    = action_overrides(action);
    assign loop_done   = action_finishes(action);
    assign loop_active = (state_q == ZS_RUN);

    AST_EXIT_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (loop_done && loop_active) |=> !loop_active); // R6

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        loop_done |=> !loop_done); // R6

    AST_SINGLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        (loop_active && start_q == end_q && pc == end_q && !loop_done)
            |-> (next_pc == pc)); // R8

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!loop_active && !$past(setup_valid)) |-> (!redirect && !loop_done)); // R2

endmodule

// File: tb/zloop_ctrl_tb.sv
module zloop_ctrl_tb;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W = 16;
    localparam int CNT_W  = 16;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              setup_valid = 1'b0;
    logic [ADDR_W-1:0] setup_start = '0;
    logic [ADDR_W-1:0] setup_end = '0;
    logic [CNT_W-1:0]  setup_count = '0;
    logic [ADDR_W-1:0] pc = '0;
    logic [ADDR_W-1:0] next_pc;
    logic              redirect;
    logic              loop_active;
    logic              loop_done;
    logic              setup_err;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    zloop_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dut (
        .clk (clk), .rst (rst), .setup_valid (setup_valid),
        .setup_start (setup_start), .setup_end (setup_end),
        .setup_count (setup_count), .pc (pc), .next_pc (next_pc),
        .redirect (redirect), .loop_active (loop_active),
        .loop_done (loop_done), .setup_err (setup_err)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic test_reset();
        @(negedge clk);
        pc = 16'h0010;
        #1;
        check("R1 active", 32'(loop_active), 0);
        check("R1 redirect", 32'(redirect), 0);
        check("R1 done", 32'(loop_done), 0);
        check("R1 err", 32'(setup_err), 0);
        check("R1 next_pc", 32'(next_pc), 32'h11);
        rst = 1'b0;
    endtask

    task automatic test_idle();
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            pc = 16'(16'h0100 + i * 16'h0333);
            #1;
            check("R2 next_pc", 32'(next_pc), 32'(16'(pc + 16'd1)));
            check("R2 redirect", 32'(redirect), 0);
        end
    endtask

    // Runs a loop with the fetch model pc <= next_pc; optionally injects a busy setup.
    task automatic run_loop(input logic [15:0] s, input logic [15:0] e,
                            input logic [15:0] n, input bit inject);
        int passes = 0;
        int held = 0;
        bit seen_done = 0;
        logic [15:0] nxt;
        @(negedge clk);
        setup_valid = 1'b1; setup_start = s; setup_end = e; setup_count = n;
        pc = 16'(s - 16'd4);
        @(negedge clk);
        setup_valid = 1'b0;
        pc = s;
        #1;
        check("R3 active after setup", 32'(loop_active), 1);
        for (int cyc = 0; cyc < 400; cyc++) begin
            if (inject && cyc == 0) begin
                setup_valid = 1'b1; setup_start = 16'h7000;
                setup_end = 16'h7001; setup_count = 16'd9;
                #1;
                check("R9 err while busy", 32'(setup_err), 1);
            end
            if (pc == e) begin
                passes++;
                if (s == e && !loop_done) begin
                    held++;
                    check("R8 pc held", 32'(next_pc), 32'(pc));
                end
                if (!loop_done) begin
                    check("R4 redirect", 32'(redirect), 1);
                    check("R4 target", 32'(next_pc), 32'(s));
                end
            end else begin
                check("R5 sequential", 32'(next_pc), 32'(16'(pc + 16'd1)));
                check("R5 no redirect", 32'(redirect), 0);
            end
            if (loop_done) begin
                seen_done = 1;
                check("R6 release", 32'(next_pc), 32'(16'(e + 16'd1)));
                check("R6 no redirect", 32'(redirect), 0);
                break;
            end
            nxt = next_pc;
            @(negedge clk);
            setup_valid = 1'b0;
            pc = nxt;
            #1;
        end
        check("R6 done seen", 32'(seen_done), 1);
        check("R10 pass count", 32'(passes), 32'(n));
        if (s == e) check("R8 held cycles", 32'(held), 32'(n - 16'd1));
        @(negedge clk);
        pc = 16'(e + 16'd1);
        #1;
        check("R6 inactive after", 32'(loop_active), 0);
        check("R6 done one cycle", 32'(loop_done), 0);
    endtask

    task automatic test_skip();
        @(negedge clk);
        setup_valid = 1'b1; setup_start = 16'h0400; setup_end = 16'h0408;
        setup_count = 16'd0; pc = 16'h03F0;
        @(negedge clk);
        setup_valid = 1'b1; setup_count = 16'd2; pc = 16'h03F1;
        #1;
        check("R7 redirect", 32'(redirect), 1);
        check("R7 target", 32'(next_pc), 32'h0409);
        check("R7 done", 32'(loop_done), 1);
        check("R7 never active", 32'(loop_active), 0);
        check("R9 err during skip", 32'(setup_err), 1);
        @(negedge clk);
        setup_valid = 1'b0; pc = 16'h0409;
        #1;
        check("R7 idle after", 32'(redirect), 0);
        check("R9 skip setup ignored", 32'(loop_active), 0);
        check("R7 next seq", 32'(next_pc), 32'h040A);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        test_reset();
        test_idle();
        run_loop(16'h0020, 16'h0024, 16'd3, 0);
        run_loop(16'h0040, 16'h0042, 16'd1, 0);
        run_loop(16'h0060, 16'h0060, 16'd5, 0);
        run_loop(16'h0080, 16'h0083, 16'd4, 1);
        test_skip();
        run_loop(16'h0200, 16'h0201, 16'd5, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule